// File: doc/BRIEF.md
# Dual-Plane Page-Write Memory

This block models a byte-wide nonvolatile memory that sits on a multiplexed address/data bus. The host places the low address byte on the shared bus and latches it with an address strobe, while the upper address bits arrive on separate pins. A data strobe then performs either a read or a write, depending on the read/write select. Writes are not stored at once. They collect in a page buffer, and each accepted write restarts an inactivity window. When the window runs out, the page is closed and a timed programming cycle copies the loaded bytes into the storage array.

The array is split into two planes by the top address bit. While a page is being loaded or programmed, a read of the busy plane returns a polling byte with a toggling bit, so the host can tell when programming has finished. A read of the other plane returns true data during the same period. This lets one part hold code and data at the same time. The window length and the programming length are both given in clock cycles.

Top module: `dualPlanePageMem`

## Requirements
- R1: While `ceN` is high, strobes have no effect. No byte is written or loaded, no address is captured, and `dataOe` stays low with `dataOut` at zero.
- R2: `dataOe` is high in the cycle after a clock edge that samples `ceN` low, `rwN` high and `eIn` high, and it is low otherwise. While `dataOe` is low, `dataOut` is zero.
- R3: The address `{adHi, adIn}` is captured at the clock edge that first samples `asIn` low after it was high, provided `ceN` is low. It is used by every later read and write until the next capture.
- R4: A rising `eIn` with `ceN` low and `rwN` low is a write. The byte on `adIn` goes into the page slot picked by address bits [4:0]. If no page is open, the write opens one whose tag is address bits [ADDR_W-1:5].
- R5: Each accepted write restarts the load window. Programming starts at the edge where WIN_CYC edges have passed since the last accepted write with no new accepted write. A page may therefore collect up to 32 bytes over any span of time.
- R6: A write whose address bits [ADDR_W-1:5] differ from the open page tag is ignored and does not restart the window. A write made during programming is ignored.
- R7: Programming stores only the loaded bytes of the page. Other bytes of that page keep their previous contents. After programming, a read of any stored byte returns its data.
- R8: While a page is open or programming, a read whose top address bit equals the top bit of the page tag returns a polling byte. Bit 6 is 1 on the first such read and inverts on each later one, and all other bits are 0. The toggle returns to its start value when programming ends.
- R9: While a page is open or programming, a read of the other plane returns true array data.
- R10: Programming lasts PROG_CYC cycles. After it ends, a new write opens a new page, and that page is programmed in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip select |
| asIn | input | 1 | Address strobe; its falling edge captures the address |
| eIn | input | 1 | Data strobe; its rising edge performs the access |
| rwN | input | 1 | High selects read, low selects write |
| adIn | input | 8 | Shared bus: low address byte, or write data |
| adHi | input | ADDR_W-8 | Upper address bits |
| dataOut | output | 8 | Read data, zero when not driven |
| dataOe | output | 1 | Output drive enable for the shared bus |

## Verification
A read result and its drive enable are due directly after the first rising clock edge that samples `eIn` high with a read selected. An address capture takes effect at the edge that samples `asIn` low. The bench samples every output 2 ns after each rising edge, and compares it with a behavioural model that advances on that same edge.

Programming begins WIN_CYC+1 edges after the last accepted write edge. It commits one page slot per edge over the next 32 edges, and the busy period ends PROG_CYC edges after it began. Directed reads are therefore placed only after waits longer than WIN_CYC+PROG_CYC, or inside the busy span when a polling byte is expected.

// File: rtl/dpmPkg.sv
package dpmPkg;
  parameter int PAGE_AW = 5;
  localparam int PAGE_BYTES = 1 << PAGE_AW;

  typedef struct packed {
    logic               latchAddr;
    logic               loadByte;
    logic               openPage;
    logic               commitEn;
    logic [PAGE_AW-1:0] commitIdx;
    logic               readEn;
    logic               readPoll;
    logic               driveOut;
    logic               clearPage;
  } ctrlStrobes_t;
endpackage

// File: rtl/dpmCtrl.sv
module dpmCtrl
  import dpmPkg::*;
#(
  parameter int WIN_CYC  = 20,
  parameter int PROG_CYC = 40
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ceN,
  input  logic         asIn,
  input  logic         eIn,
  input  logic         rwN,
  input  logic         tagHit,
  input  logic         planeHit,
  output ctrlStrobes_t st
);
  localparam int CNT_MAX = (WIN_CYC > PROG_CYC) ? WIN_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  typedef enum logic [1:0] {IDLE, LOAD, PROG} phase_t;

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_AW:0]  idx;
  logic              eQ, asQ;
  logic              sel, eRise, wrRise, rdRise, cntZero;

  always_comb begin
    sel     = ~ceN;
    eRise   = eIn & ~eQ;
    wrRise  = sel & ~rwN & eRise;
    rdRise  = sel & rwN & eRise;
    cntZero = (cnt == '0);

    st           = '0;
    st.latchAddr = sel & asQ & ~asIn;
    st.driveOut  = sel & rwN & eIn;
    st.readEn    = rdRise;
    st.readPoll  = rdRise & (phase != IDLE) & planeHit;
    st.openPage  = (phase == IDLE) & wrRise;
    st.loadByte  = st.openPage | ((phase == LOAD) & wrRise & tagHit);
    st.commitEn  = (phase == PROG) & ~idx[PAGE_AW];
    st.commitIdx = idx[PAGE_AW-1:0];
    st.clearPage = (phase == PROG) & cntZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eQ    <= 1'b0;
      asQ   <= 1'b0;
      phase <= IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      eQ  <= eIn;
      asQ <= asIn;
      unique case (phase)
        IDLE: begin
          if (wrRise) begin
            phase <= LOAD;
            cnt   <= CNT_W'(WIN_CYC - 1);
          end
        end
        LOAD: begin
          if (wrRise && tagHit) begin
            cnt <= CNT_W'(WIN_CYC - 1);
          end else if (cntZero) begin
            phase <= PROG;
            cnt   <= CNT_W'(PROG_CYC - 1);
            idx   <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PROG: begin
          if (!idx[PAGE_AW]) idx <= idx + 1'b1;
          if (cntZero) phase <= IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: phase <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dpmData.sv
module dpmData
  import dpmPkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       st,
  input  logic [DATA_W-1:0]  adIn,
  input  logic [ADDR_W-DATA_W-1:0] adHi,
  output logic               tagHit,
  output logic               planeHit,
  output logic [DATA_W-1:0]  dataOut,
  output logic               dataOe
);
  localparam int TAG_W   = ADDR_W - PAGE_AW;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int TOG_BIT = 6;

  logic [ADDR_W-1:0]  addrQ;
  logic [TAG_W-1:0]   pageTag;
  logic [DATA_W-1:0]  pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageVld;
  logic [DATA_W-1:0]  mem [DEPTH];
  logic [DATA_W-1:0]  rdData;
  logic [DATA_W-1:0]  pollByte;
  logic               tog;
  logic               oeQ;

  always_comb begin
    tagHit            = (addrQ[ADDR_W-1:PAGE_AW] == pageTag);
    planeHit          = (addrQ[ADDR_W-1] == pageTag[TAG_W-1]);
    pollByte          = '0;
    pollByte[TOG_BIT] = ~tog;
    dataOe            = oeQ;
    dataOut           = oeQ ? rdData : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      pageTag <= '0;
      pageVld <= '0;
      tog     <= 1'b0;
      rdData  <= '0;
      oeQ     <= 1'b0;
    end else begin
      oeQ <= st.driveOut;
      if (st.latchAddr) addrQ <= {adHi, adIn};
      if (st.openPage) pageTag <= addrQ[ADDR_W-1:PAGE_AW];
      if (st.clearPage) pageVld <= '0;
      else if (st.loadByte) pageVld[addrQ[PAGE_AW-1:0]] <= 1'b1;
      if (st.clearPage) tog <= 1'b0;
      else if (st.readPoll) tog <= ~tog;
      if (st.readEn) rdData <= st.readPoll ? pollByte : mem[addrQ];
    end
  end

  always_ff @(posedge clk) begin
    if (st.loadByte) pageBuf[addrQ[PAGE_AW-1:0]] <= adIn;
  end

  always_ff @(posedge clk) begin
    if (st.commitEn && pageVld[st.commitIdx])
      mem[{pageTag, st.commitIdx}] <= pageBuf[st.commitIdx];
  end
endmodule

// File: rtl/dualPlanePageMem.sv
module dualPlanePageMem
  import dpmPkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int WIN_CYC  = 20,
  parameter int PROG_CYC = 40
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ceN,
  input  logic                     asIn,
  input  logic                     eIn,
  input  logic                     rwN,
  input  logic [DATA_W-1:0]        adIn,
  input  logic [ADDR_W-DATA_W-1:0] adHi,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     dataOe
);
  ctrlStrobes_t st;
  logic tagHit, planeHit;

  dpmCtrl #(.WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .asIn(asIn), .eIn(eIn), .rwN(rwN),
    .tagHit(tagHit), .planeHit(planeHit), .st(st)
  );

  dpmData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) data_i (
    .clk(clk), .rstN(rstN), .st(st), .adIn(adIn), .adHi(adHi),
    .tagHit(tagHit), .planeHit(planeHit), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/dpmChecker.sv
module dpmChecker
  import dpmPkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              rwN,
  input logic              eIn,
  input logic              dataOe,
  input logic [DATA_W-1:0] dataOut,
  input ctrlStrobes_t      st
);
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(ceN) |-> !dataOe); // R1

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> ($past(rwN) && $past(eIn) && !$past(ceN))); // R2

  AST_OPEN_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    st.openPage |-> (!ceN && !rwN && eIn)); // R4

  AST_NO_LOAD_IN_PROG: assert property (@(posedge clk) disable iff (!rstN)
    st.commitEn |-> !st.loadByte); // R6

  AST_COMMIT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (st.commitEn && $past(st.commitEn)) |-> (st.commitIdx == PAGE_AW'($past(st.commitIdx) + 1'b1))); // R7

  AST_POLL_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    st.readPoll |=> ((dataOut & ~DATA_W'(64)) == '0)); // R8
endmodule

bind dualPlanePageMem dpmChecker #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .ceN(ceN), .rwN(rwN), .eIn(eIn),
  .dataOe(dataOe), .dataOut(dataOut), .st(st)
);

// File: tb/dualPlanePageMem_tb_top.sv
`timescale 1ns/1ps
module dualPlanePageMem_tb_top;
  localparam int ADDR_W = 10;
  localparam int HI_W   = ADDR_W - 8;
  localparam int WIN    = 20;
  localparam int PROG   = 40;
  localparam int SETTLE = WIN + PROG + 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, asIn = 1'b0, eIn = 1'b0, rwN = 1'b1;
  logic [7:0] adIn = '0;
  logic [HI_W-1:0] adHi = '0;
  logic [7:0] dataOut;
  logic dataOe;

  int nChecks = 0, nErrors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dualPlanePageMem #(.ADDR_W(ADDR_W), .DATA_W(8), .WIN_CYC(WIN), .PROG_CYC(PROG)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .asIn(asIn), .eIn(eIn), .rwN(rwN),
    .adIn(adIn), .adHi(adHi), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mPhase, mCnt, mIdx, mTag, mAddr;
  bit mPrevE, mPrevAs, mTog;
  logic [7:0] pbuf [32];
  bit pvld [32];
  logic [7:0] mmem [int];
  logic [7:0] expRd;
  bit expOe, rdKnown;
  string oeReq = "R2", rdReq = "R2";

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0; mIdx = 0; mTag = 0; mAddr = 0;
      mPrevE = 0; mPrevAs = 0; mTog = 0;
      foreach (pvld[i]) pvld[i] = 0;
      expRd = '0; expOe = 0; rdKnown = 1; oeReq = "R2";
    end else begin
      automatic bit sel  = !ceN;
      automatic bit rise = eIn && !mPrevE;
      automatic bit wr   = sel && !rwN && rise;
      automatic bit rd   = sel && rwN && rise;
      if (rd) begin
        if (mPhase != 0 && ((mAddr >> 9) & 1) == ((mTag >> 4) & 1)) begin
          mTog = !mTog; expRd = mTog ? 8'h40 : 8'h00; rdKnown = 1; rdReq = "R8";
        end else begin
          rdKnown = mmem.exists(mAddr);
          expRd   = rdKnown ? mmem[mAddr] : 8'h00;
          rdReq   = (mPhase != 0) ? "R9" : "R7";
        end
      end
      expOe = sel && rwN && eIn;
      oeReq = ceN ? "R1" : "R2";
      case (mPhase)
        0: if (wr) begin
             mTag = mAddr >> 5; pbuf[mAddr & 31] = adIn; pvld[mAddr & 31] = 1;
             mPhase = 1; mCnt = WIN - 1;
           end
        1: if (wr && (mAddr >> 5) == mTag) begin
             pbuf[mAddr & 31] = adIn; pvld[mAddr & 31] = 1; mCnt = WIN - 1;
           end else if (mCnt == 0) begin
             mPhase = 2; mCnt = PROG - 1; mIdx = 0;
           end else mCnt--;
        default: begin
          if (mIdx < 32) begin
            if (pvld[mIdx]) mmem[mTag * 32 + mIdx] = pbuf[mIdx];
            mIdx++;
          end
          if (mCnt == 0) begin
            mPhase = 0; mTog = 0;
            foreach (pvld[i]) pvld[i] = 0;
          end else mCnt--;
        end
      endcase
      if (sel && mPrevAs && !asIn) mAddr = {adHi, adIn};
      mPrevE = eIn; mPrevAs = asIn;
    end
  end

  // compare on every clock, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk(oeReq, {7'b0, dataOe}, {7'b0, expOe});
      if (!expOe) chk(oeReq, dataOut, 8'h00);
      else if (rdKnown) chk(rdReq, dataOut, expRd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic latchAddr(input int addr);
    @(negedge clk);
    ceN = 0; {adHi, adIn} = addr[ADDR_W-1:0]; asIn = 1;
    @(negedge clk); asIn = 0;
    @(negedge clk);
  endtask

  task automatic writeByte(input int addr, input logic [7:0] d);
    latchAddr(addr);
    rwN = 0; adIn = d; eIn = 1;
    @(negedge clk); eIn = 0; rwN = 1;
  endtask

  task automatic readCheck(input int addr, input logic [7:0] exp, input string req);
    latchAddr(addr);
    rwN = 1; eIn = 1;
    @(posedge clk); #2;
    chk(req, {7'b0, dataOe}, 8'h01);
    chk(req, dataOut, exp);
    @(negedge clk); eIn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(posedge clk); #2;
    chk("R2", {7'b0, dataOe}, 8'h00);   // reset state
    chk("R2", dataOut, 8'h00);

    // R5: a full page loaded over far more than one window, then R8 polling
    for (int i = 0; i < 32; i++) writeByte(32'h040 + i, 8'(i) ^ 8'h5A);
    readCheck(32'h040, 8'h40, "R8");
    readCheck(32'h040, 8'h00, "R8");
    idle(SETTLE);
    readCheck(32'h040, 8'h5A, "R5");
    readCheck(32'h05F, 8'h45, "R7");

    // single byte in plane 1 for later R6 check
    writeByte(32'h240, 8'h77);
    idle(SETTLE);

    // plane-1 page; mismatched tag ignored; plane-0 reads true data
    writeByte(32'h220, 8'h11);
    writeByte(32'h233, 8'h22);
    writeByte(32'h240, 8'h99);           // R6: other page, ignored
    readCheck(32'h041, 8'h5B, "R9");
    readCheck(32'h220, 8'h40, "R8");
    idle(SETTLE);
    readCheck(32'h233, 8'h22, "R7");
    readCheck(32'h240, 8'h77, "R6");

    // R7 partial page keeps other bytes; R6 write during programming ignored
    writeByte(32'h043, 8'hC3);
    idle(WIN + 6);
    writeByte(32'h045, 8'hEE);
    idle(SETTLE);
    readCheck(32'h043, 8'hC3, "R7");
    readCheck(32'h044, 8'h5E, "R7");
    readCheck(32'h045, 8'h5F, "R6");

    // R10: new page accepted after programming
    writeByte(32'h046, 8'hAB);
    idle(SETTLE);
    readCheck(32'h046, 8'hAB, "R10");

    // R1: standby ignores write and read strobes
    latchAddr(32'h047);
    ceN = 1; rwN = 0; adIn = 8'h12; eIn = 1;
    @(negedge clk); eIn = 0; rwN = 1;
    @(negedge clk); eIn = 1;
    @(posedge clk); #2;
    chk("R1", {7'b0, dataOe}, 8'h00);
    @(negedge clk); eIn = 0; ceN = 0;
    idle(SETTLE);
    readCheck(32'h047, 8'h5D, "R1");

    // R3: address strobe in standby does not capture
    latchAddr(32'h041);
    ceN = 1; adIn = 8'h05; adHi = '0; asIn = 1;
    @(negedge clk); asIn = 0;
    @(negedge clk); ceN = 0; rwN = 1; eIn = 1;
    @(posedge clk); #2;
    chk("R3", dataOut, 8'h5B);
    @(negedge clk); eIn = 0;
    idle(4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nErrors++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end
endmodule